// File: doc/BRIEF.md
# Test Sequence Generator and Checker

This block tests links and physical interfaces. The transmit half sends a continuous stream of test words, one per clock, on a valid/data output. The stream is either pseudo-random, taken from a maximal-length shift register, or an incrementing counter that wraps at a programmable value. The receive half watches a valid/data input that normally carries the same stream after it has crossed the link. It reports one of four verdicts: ok, not run, timeout, or data error.

A small bank of data-wide registers controls both halves. The bank holds the transmit seed, the wrap value and the transmit mode. It also holds the receive mode, four receive step values and a timeout limit. The same bank returns read-only status: the transmit word count, the receive word count, the verdict and the last received word. The receiver predicts each word from the word before it, so it can be armed while a stream is already running.

Top module: `seqtest_top`

## Requirements
- R1: After reset, tx_valid is 0, the verdict reads 1 (not run), and both word counts read 0. The seed resets to 1, the wrap value to 0, all steps to 1 and the timeout limit to 1000.
- R2: The mode registers decode the values 0 (off), 1 (pseudo-random) and 3 (counter). Any other value means off. The transmit mode is at address 2 and the receive mode at address 3. Writing mode 1 or 3 to the transmit mode presents the seed (address 0) on tx_data with tx_valid high in the following cycle. When the mode is off, tx_valid is low.
- R3: In counter mode, each next word is the previous word plus 1. When that sum equals a nonzero wrap value (address 1), the next word is 0 instead. A wrap value of 0 lets the counter run freely.
- R4: In pseudo-random mode, each next word is the previous word shifted left by one bit. The feedback bit (bit 30 XOR bit 27 of the previous word) enters at bit 0.
- R5: The transmit count (address 9) adds 1 for every clock edge at which tx_valid is high. Enabling a transmit mode clears it. Writing off leaves it holding its value.
- R6: In receive counter mode, a word is accepted if it equals the previous received word plus any one of the four step registers (addresses 4 to 7), modulo 2^32.
- R7: In receive pseudo-random mode, a word is accepted if it equals the R4 successor of the previous received word. The first word after arming only seeds the check, so the receiver self-synchronises to a running stream.
- R8: The verdict (address 11) reads 1 from arming until the first valid word arrives. After that it reads 0 while every word has been accepted.
- R9: A rejected word makes the verdict read 3. It stays 3 until the receive mode is written again.
- R10: If no valid word arrives within the timeout limit (address 8) of cycles after arming, the verdict reads 2 from the cycle after the limit-th edge and stays 2. A valid word that arrives earlier cancels the timeout.
- R11: The receive count (address 10) adds 1 for each valid word received while armed. The last received word is readable at address 12. Every write of the receive mode clears the count.
- R12: While the receive mode is off, valid input words do not change the receive count, the last received word or the verdict.
- R13: The verdict never takes the value 4, which is reserved for an illegal internal state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| tx_valid | output | 1 | Transmit word valid |
| tx_data | output | 32 | Transmit test word |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | 32 | Receive word |

## Verification
The bench builds the block with its default parameters: 32-bit words, four steps, a 16-bit timeout and taps at bits 31 and 28. It then reaches the corner cases through register values. A wrap value of 8 forces a counter wraparound within a few words. A second step of -7 shows that a wraparound is accepted only when a matching step is programmed. A timeout limit of 10 places the timeout edge where the bench can sample the cycle just before it and the cycle just after it. The loopback from transmit to receive can be broken, so the bench can drive lone words, corrupt one word, or arm the receiver while a stream is already running.

// File: rtl/seqtest_pkg.sv
package seqtest_pkg;
  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] ADR_TX_SEED = 4'd0;
  localparam logic [REG_AW-1:0] ADR_TX_WRAP = 4'd1;
  localparam logic [REG_AW-1:0] ADR_TX_MODE = 4'd2;
  localparam logic [REG_AW-1:0] ADR_RX_MODE = 4'd3;
  localparam logic [REG_AW-1:0] ADR_STEP0   = 4'd4;
  localparam logic [REG_AW-1:0] ADR_RX_TMO  = 4'd8;
  localparam logic [REG_AW-1:0] ADR_TX_CNT  = 4'd9;
  localparam logic [REG_AW-1:0] ADR_RX_CNT  = 4'd10;
  localparam logic [REG_AW-1:0] ADR_VERDICT = 4'd11;
  localparam logic [REG_AW-1:0] ADR_RX_LAST = 4'd12;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_PRBS = 2'd1,
    SRC_CNT  = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    VD_OK   = 3'd0,
    VD_NONE = 3'd1,
    VD_TMO  = 3'd2,
    VD_ERR  = 3'd3,
    VD_ILL  = 3'd4
  } verdict_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_WAIT,
    RX_RUN,
    RX_TMO
  } rxst_e;
endpackage

// File: rtl/seqtest_lfsr_step.sv
module seqtest_lfsr_step #(
  parameter int unsigned W     = 32,
  parameter int unsigned TAP_A = 31,
  parameter int unsigned TAP_B = 28
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic fb;
  assign fb  = cur[TAP_A-1] ^ cur[TAP_B-1];
  assign nxt = (cur << 1) | W'(fb);
endmodule

// File: rtl/seqtest_regs.sv
module seqtest_regs
  import seqtest_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NSTEP  = 4,
  parameter int unsigned TMO_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_ni,
  input  logic                         wr,
  input  logic [REG_AW-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  input  logic [DATA_W-1:0]            tx_cnt,
  input  logic [DATA_W-1:0]            rx_cnt,
  input  logic [DATA_W-1:0]            rx_last,
  input  verdict_e                     verdict,
  output logic [DATA_W-1:0]            seed,
  output logic [DATA_W-1:0]            wrap,
  output src_e                         tx_src,
  output src_e                         rx_src,
  output src_e                         new_src,
  output logic [NSTEP-1:0][DATA_W-1:0] steps,
  output logic [TMO_W-1:0]             tmo,
  output logic                         tx_start,
  output logic                         rx_load
);
  logic [DATA_W-1:0]            seed_q, seed_n, wrap_q, wrap_n;
  src_e                         tx_src_q, tx_src_n, rx_src_q, rx_src_n;
  logic [NSTEP-1:0][DATA_W-1:0] steps_q, steps_n;
  logic [TMO_W-1:0]             tmo_q, tmo_n;

  always_comb begin
    if (wdata == DATA_W'(1))      new_src = SRC_PRBS;
    else if (wdata == DATA_W'(3)) new_src = SRC_CNT;
    else                          new_src = SRC_OFF;
  end

  assign tx_start = wr && (addr == ADR_TX_MODE) && (new_src != SRC_OFF);
  assign rx_load  = wr && (addr == ADR_RX_MODE);

  always_comb begin
    seed_n   = seed_q;
    wrap_n   = wrap_q;
    tx_src_n = tx_src_q;
    rx_src_n = rx_src_q;
    steps_n  = steps_q;
    tmo_n    = tmo_q;
    if (wr) begin
      case (addr)
        ADR_TX_SEED: seed_n   = wdata;
        ADR_TX_WRAP: wrap_n   = wdata;
        ADR_TX_MODE: tx_src_n = new_src;
        ADR_RX_MODE: rx_src_n = new_src;
        ADR_RX_TMO:  tmo_n    = wdata[TMO_W-1:0];
        default: begin
          for (int i = 0; i < NSTEP; i++)
            if (addr == ADR_STEP0 + REG_AW'(i)) steps_n[i] = wdata;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q   <= DATA_W'(1);
      wrap_q   <= '0;
      tx_src_q <= SRC_OFF;
      rx_src_q <= SRC_OFF;
      for (int i = 0; i < NSTEP; i++) steps_q[i] <= DATA_W'(1);
      tmo_q    <= TMO_W'(1000);
    end else begin
      seed_q   <= seed_n;
      wrap_q   <= wrap_n;
      tx_src_q <= tx_src_n;
      rx_src_q <= rx_src_n;
      steps_q  <= steps_n;
      tmo_q    <= tmo_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_TX_SEED: rdata = seed_q;
      ADR_TX_WRAP: rdata = wrap_q;
      ADR_TX_MODE: rdata = DATA_W'(tx_src_q);
      ADR_RX_MODE: rdata = DATA_W'(rx_src_q);
      ADR_RX_TMO:  rdata = DATA_W'(tmo_q);
      ADR_TX_CNT:  rdata = tx_cnt;
      ADR_RX_CNT:  rdata = rx_cnt;
      ADR_VERDICT: rdata = DATA_W'(verdict);
      ADR_RX_LAST: rdata = rx_last;
      default: begin
        for (int i = 0; i < NSTEP; i++)
          if (addr == ADR_STEP0 + REG_AW'(i)) rdata = steps_q[i];
      end
    endcase
  end

  assign seed   = seed_q;
  assign wrap   = wrap_q;
  assign tx_src = tx_src_q;
  assign rx_src = rx_src_q;
  assign steps  = steps_q;
  assign tmo    = tmo_q;
endmodule

// File: rtl/seqtest_gen.sv
module seqtest_gen
  import seqtest_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned TAP_A = 31,
  parameter int unsigned TAP_B = 28
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         start,
  input  src_e         src,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] wrap,
  output logic         valid,
  output logic [W-1:0] data,
  output logic [W-1:0] count
);
  logic [W-1:0] word_q, word_n, cnt_q, cnt_n, prbs_nxt, inc;

  seqtest_lfsr_step #(.W(W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_step (
    .cur(word_q),
    .nxt(prbs_nxt)
  );

  assign inc = word_q + W'(1);

  always_comb begin
    word_n = word_q;
    cnt_n  = cnt_q;
    if (start) begin
      word_n = seed;
      cnt_n  = '0;
    end else if (src != SRC_OFF) begin
      cnt_n = cnt_q + W'(1);
      if (src == SRC_PRBS)                  word_n = prbs_nxt;
      else if (wrap != '0 && inc == wrap)   word_n = '0;
      else                                  word_n = inc;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_n;
      cnt_q  <= cnt_n;
    end
  end

  assign valid = (src != SRC_OFF);
  assign data  = word_q;
  assign count = cnt_q;
endmodule

// File: rtl/seqtest_chk.sv
module seqtest_chk
  import seqtest_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned NSTEP = 4,
  parameter int unsigned TMO_W = 16,
  parameter int unsigned TAP_A = 31,
  parameter int unsigned TAP_B = 28
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    restart,
  input  src_e                    new_src,
  input  src_e                    src,
  input  logic [NSTEP-1:0][W-1:0] steps,
  input  logic [TMO_W-1:0]        tmo,
  input  logic                    in_valid,
  input  logic [W-1:0]            in_data,
  output verdict_e                verdict,
  output logic [W-1:0]            count,
  output logic [W-1:0]            last
);
  rxst_e            st_q, st_n;
  logic             err_q, err_n, have_q, have_n;
  logic [W-1:0]     cnt_q, cnt_n, last_q, last_n, prbs_exp;
  logic [TMO_W-1:0] tmo_q, tmo_n;
  logic [NSTEP-1:0] hit;
  logic             match;

  seqtest_lfsr_step #(.W(W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_pred (
    .cur(last_q),
    .nxt(prbs_exp)
  );

  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    assign hit[g] = (in_data == last_q + steps[g]);
  end

  assign match = (src == SRC_PRBS) ? (in_data == prbs_exp) : (|hit);

  always_comb begin
    st_n   = st_q;
    err_n  = err_q;
    have_n = have_q;
    cnt_n  = cnt_q;
    last_n = last_q;
    tmo_n  = tmo_q;
    if (restart) begin
      st_n   = (new_src == SRC_OFF) ? RX_IDLE : RX_WAIT;
      err_n  = 1'b0;
      have_n = 1'b0;
      cnt_n  = '0;
      tmo_n  = '0;
    end else if (src != SRC_OFF) begin
      if (in_valid) begin
        cnt_n  = cnt_q + W'(1);
        last_n = in_data;
        have_n = 1'b1;
        if (have_q && !match) err_n = 1'b1;
        if (st_q == RX_WAIT)  st_n  = RX_RUN;
      end else if (st_q == RX_WAIT) begin
        if ((TMO_W+1)'(tmo_q) + (TMO_W+1)'(1) >= (TMO_W+1)'(tmo)) st_n = RX_TMO;
        else tmo_n = tmo_q + TMO_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      err_q  <= 1'b0;
      have_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
      tmo_q  <= '0;
    end else begin
      st_q   <= st_n;
      err_q  <= err_n;
      have_q <= have_n;
      cnt_q  <= cnt_n;
      last_q <= last_n;
      tmo_q  <= tmo_n;
    end
  end

  always_comb begin
    case (st_q)
      RX_IDLE, RX_WAIT: verdict = VD_NONE;
      RX_RUN:           verdict = err_q ? VD_ERR : VD_OK;
      RX_TMO:           verdict = VD_TMO;
      default:          verdict = VD_ILL;
    endcase
  end

  assign count = cnt_q;
  assign last  = last_q;
endmodule

// File: rtl/seqtest_top.sv
module seqtest_top
  import seqtest_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NSTEP  = 4,
  parameter int unsigned TMO_W  = 16,
  parameter int unsigned TAP_A  = 31,
  parameter int unsigned TAP_B  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data
);
  logic [1:0]                   rst_sync;
  logic                         rst_ni;
  logic [DATA_W-1:0]            seed, wrap, tx_count, rx_count, rx_last;
  src_e                         tx_src, rx_src, new_src;
  logic [NSTEP-1:0][DATA_W-1:0] steps;
  logic [TMO_W-1:0]             tmo;
  logic                         tx_start, rx_load;
  verdict_e                     verdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  seqtest_regs #(.DATA_W(DATA_W), .NSTEP(NSTEP), .TMO_W(TMO_W)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .tx_cnt(tx_count), .rx_cnt(rx_count), .rx_last(rx_last), .verdict(verdict),
    .seed(seed), .wrap(wrap), .tx_src(tx_src), .rx_src(rx_src),
    .new_src(new_src), .steps(steps), .tmo(tmo),
    .tx_start(tx_start), .rx_load(rx_load)
  );

  seqtest_gen #(.W(DATA_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_gen (
    .clk(clk), .rst_ni(rst_ni), .start(tx_start), .src(tx_src),
    .seed(seed), .wrap(wrap), .valid(tx_valid), .data(tx_data),
    .count(tx_count)
  );

  seqtest_chk #(.W(DATA_W), .NSTEP(NSTEP), .TMO_W(TMO_W),
                .TAP_A(TAP_A), .TAP_B(TAP_B)) u_chk (
    .clk(clk), .rst_ni(rst_ni), .restart(rx_load), .new_src(new_src),
    .src(rx_src), .steps(steps), .tmo(tmo), .in_valid(rx_valid),
    .in_data(rx_data), .verdict(verdict), .count(rx_count), .last(rx_last)
  );
endmodule

// File: rtl/seqtest_sva.sv
module seqtest_sva #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_ni,
  input logic         reg_wr,
  input logic [3:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic         tx_valid,
  input logic [W-1:0] tx_count,
  input logic [W-1:0] rx_count,
  input logic [2:0]   verdict
);
  logic tx_wr, tx_on_wr, rx_wr;
  assign tx_wr    = reg_wr && reg_addr == 4'd2;
  assign tx_on_wr = tx_wr && (reg_wdata == W'(1) || reg_wdata == W'(3));
  assign rx_wr    = reg_wr && reg_addr == 4'd3;

  // R2: writing off to the transmit mode drops tx_valid
  a_r2_off_stops: assert property (@(posedge clk) disable iff (!rst_n || !rst_ni)
    (tx_wr && reg_wdata == '0) |=> !tx_valid);

  // R2: enabling a mode raises tx_valid
  a_r2_on_starts: assert property (@(posedge clk) disable iff (!rst_n || !rst_ni)
    tx_on_wr |=> tx_valid);

  // R5: each valid edge adds one word to the transmit count
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n || !rst_ni)
    (tx_valid && !tx_on_wr) |=> tx_count == $past(tx_count) + W'(1));

  // R9: the error verdict is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n || !rst_ni)
    (verdict == 3'd3 && !rx_wr) |=> verdict == 3'd3);

  // R10: the timeout verdict is sticky
  a_r10_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n || !rst_ni)
    (verdict == 3'd2 && !rx_wr) |=> verdict == 3'd2);

  // R11: a receive mode write clears the receive count
  a_r11_rx_clear: assert property (@(posedge clk) disable iff (!rst_n || !rst_ni)
    rx_wr |=> rx_count == '0);

  // R13: the reserved verdict value never shows
  a_r13_no_illegal: assert property (@(posedge clk) disable iff (!rst_n || !rst_ni)
    verdict <= 3'd3);
endmodule

bind seqtest_top seqtest_sva #(.W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .tx_valid(tx_valid),
  .tx_count(tx_count), .rx_count(rx_count), .verdict(verdict)
);

// File: tb/seqtest_top_tb_top.sv
module seqtest_top_tb_top;
  localparam logic [3:0] A_SEED = 4'd0, A_WRAP = 4'd1, A_TXM = 4'd2, A_RXM = 4'd3;
  localparam logic [3:0] A_STEP0 = 4'd4, A_TMO = 4'd8, A_TXC = 4'd9;
  localparam logic [3:0] A_RXC = 4'd10, A_VD = 4'd11, A_LAST = 4'd12;

  logic        clk, rst_n, reg_wr, tx_valid, rx_valid;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, tx_data, rx_data;
  logic        loop, drv_valid, mon_on;
  logic [31:0] drv_data, corrupt;
  int          n_chk, n_err;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  seqtest_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  assign rx_valid = loop ? tx_valid : drv_valid;
  assign rx_data  = (loop ? tx_data : drv_data) ^ corrupt;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] prbs(input logic [31:0] x);
    return {x[30:0], x[30] ^ x[27]};
  endfunction

  // driver: push the expected stream, then start the generator
  task automatic run_tx(input logic [31:0] seed, input logic [31:0] wrap,
                        input logic [31:0] mode, input int n, input string req);
    logic [31:0] x;
    wr(A_TXM, 0);
    wr(A_SEED, seed);
    wr(A_WRAP, wrap);
    x = seed;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(x);
      tag_q.push_back(req);
      if (mode == 1) x = prbs(x);
      else if (wrap != 0 && x + 1 == wrap) x = 0;
      else x = x + 1;
    end
    mon_on = 1'b1;
    wr(A_TXM, mode);
    wait (exp_q.size() == 0);
    mon_on = 1'b0;
  endtask

  // monitor: pop and compare each produced word
  always @(negedge clk) begin
    logic [31:0] e;
    string       t;
    if (mon_on && tx_valid && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, tx_data, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    loop = 1'b0; drv_valid = 1'b0; drv_data = '0; corrupt = '0; mon_on = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
    rd(A_VD, v);   check("R1 verdict", v, 32'd1);
    rd(A_TXC, v);  check("R1 tx count", v, 32'd0);
    rd(A_RXC, v);  check("R1 rx count", v, 32'd0);
    rd(A_SEED, v); check("R1 seed", v, 32'd1);
    rd(A_TMO, v);  check("R1 timeout", v, 32'd1000);

    // R3 free-running counter, R2 first word is the seed
    run_tx(32'd100, 32'd0, 32'd3, 10, "R3 counter");
    // R3 wrap at 8
    run_tx(32'd5, 32'd8, 32'd3, 12, "R3 wrap");
    // R4 pseudo-random sequence
    run_tx(32'd1, 32'd0, 32'd1, 40, "R4 prbs");
    run_tx(32'hACE1_2345, 32'd0, 32'd1, 20, "R4 prbs seed");

    // R2 reserved mode code is off
    wr(A_TXM, 32'd2);
    @(negedge clk);
    check("R2 code 2 off", {31'b0, tx_valid}, 32'd0);
    rd(A_TXM, v); check("R2 mode readback", v, 32'd0);

    // R5 transmit count: n=5 gives 7 valid edges
    wr(A_TXM, 32'd3);
    repeat (5) @(negedge clk);
    wr(A_TXM, 32'd0);
    rd(A_TXC, v); check("R5 tx count", v, 32'd7);
    repeat (3) @(negedge clk);
    rd(A_TXC, v); check("R5 count holds", v, 32'd7);

    // R6 R8 R11 counter loopback
    loop = 1'b1;
    for (int i = 0; i < 4; i++) wr(A_STEP0 + 4'(i), 32'd1);
    wr(A_SEED, 32'd100); wr(A_WRAP, 32'd0);
    wr(A_RXM, 32'd3);
    rd(A_VD, v); check("R8 armed not run", v, 32'd1);
    wr(A_TXM, 32'd3);
    repeat (20) @(negedge clk);
    wr(A_TXM, 32'd0);
    rd(A_VD, v);  check("R8 verdict ok", v, 32'd0);
    rd(A_TXC, w);
    rd(A_RXC, v); check("R11 rx count", v, w);
    rd(A_LAST, v); check("R11 last word", v, 32'd100 + w - 32'd1);

    // R6 wraparound rejected without a matching step
    wr(A_SEED, 32'd5); wr(A_WRAP, 32'd8);
    wr(A_RXM, 32'd3);
    wr(A_TXM, 32'd3);
    repeat (30) @(negedge clk);
    rd(A_VD, v); check("R6 wrap no step", v, 32'd3);
    // R6 accepted with step -7; R9 rewrite clears
    wr(A_STEP0 + 4'd1, 32'hFFFF_FFF9);
    wr(A_RXM, 32'd3);
    repeat (30) @(negedge clk);
    rd(A_VD, v); check("R6 wrap step", v, 32'd0);
    wr(A_TXM, 32'd0);

    // R7 pseudo-random loopback, armed on a running stream
    wr(A_SEED, 32'd1);
    wr(A_TXM, 32'd1);
    repeat (7) @(negedge clk);
    wr(A_RXM, 32'd1);
    repeat (30) @(negedge clk);
    rd(A_VD, v); check("R7 prbs ok", v, 32'd0);
    // R9 one corrupted word, sticky
    @(negedge clk) corrupt = 32'h0000_0100;
    @(negedge clk) corrupt = 32'd0;
    repeat (5) @(negedge clk);
    rd(A_VD, v); check("R9 error", v, 32'd3);
    repeat (20) @(negedge clk);
    rd(A_VD, v); check("R9 sticky", v, 32'd3);
    wr(A_TXM, 32'd0);
    loop = 1'b0;

    // R10 timeout at limit 10
    wr(A_TMO, 32'd10);
    wr(A_RXM, 32'd3);
    reg_addr = A_VD;
    repeat (9) @(negedge clk);
    #1 check("R10 before limit", reg_rdata, 32'd1);
    @(negedge clk);
    #1 check("R10 at limit", reg_rdata, 32'd2);

    // R10 cancelled by an early word; R11 capture
    wr(A_RXM, 32'd3);
    repeat (4) @(negedge clk);
    drv_valid = 1'b1; drv_data = 32'hDEAD_BEEF;
    @(negedge clk) drv_valid = 1'b0;
    repeat (20) @(negedge clk);
    rd(A_VD, v);   check("R10 cancelled", v, 32'd0);
    rd(A_RXC, v);  check("R11 one word", v, 32'd1);
    rd(A_LAST, v); check("R11 capture", v, 32'hDEAD_BEEF);

    // R12 disabled receiver ignores words
    wr(A_RXM, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); drv_valid = 1'b1; drv_data = 32'(i) + 32'd77;
    end
    @(negedge clk) drv_valid = 1'b0;
    repeat (20) @(negedge clk);
    rd(A_RXC, v);  check("R12 count", v, 32'd0);
    rd(A_LAST, v); check("R12 last", v, 32'hDEAD_BEEF);
    rd(A_VD, v);   check("R12 verdict", v, 32'd1);
    check("R13 not illegal", {31'b0, v == 32'd4}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule